// File: doc/BRIEF.md
# SMI Event Capture and Enable Register

This block is a 32-bit legacy-support control/status word for a USB host controller. It watches a handful of the controller's internal signals: the periodic and asynchronous schedule enables, the configure flag, the halted indication, the host-controller reset bit, a power-management status line and one ownership line per root port. Every qualifying change of one of these signals is captured in a sticky status bit. Software clears a status bit by writing 1 to it.

Each status bit has a read/write enable bit beside it. A single system-management interrupt request leaves the block whenever a captured event has its enable set. Some sources record a change in either direction. Others record only a rise to 1. Software reaches the word through a plain write strobe with write data, and a combinational read-data bus.

Top module: `smi_evt_reg`

## Requirements
- R1: A synchronous active-high reset clears every enable and status bit, so the read data is 0x00000000 and `smi_req_o` is 0 after the reset edge.
- R2: A write loads the enable bits from the write data at the same positions: bit 0 reset, bit 1 halted, bit 2 configure flag, bit 3 periodic, bit 4 async, bit 5 power-management, bits 15:14 port ownership (port 0 at bit 14). The enables read back from those positions.
- R3: Bits 13:6 and 31:24 always read as 0, including after a write of all ones.
- R4: The status bits at 19 (periodic schedule enable), 18 (configure flag), 20 (async schedule enable) and 23:22 (port ownership, port 0 at bit 22) set on a change of their input in either direction.
- R5: The status bits at 16 (controller reset bit), 17 (halted) and 21 (power-management status) set only when their input rises to 1. A fall to 0 leaves them unchanged.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: When an event and a write of 1 hit the same status bit in the same cycle, the bit ends up set.
- R8: `smi_req_o` is 1 exactly when some status bit and its enable bit are both 1. A status bit whose enable is 0 does not raise it.
- R9: A changed input is compared against a registered copy of itself and shows in the read data right after the next clock edge. An input that is held steady, including one that is already high when reset is released, records no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_per_en_i | input | 1 | Periodic schedule enable from the controller |
| sched_async_en_i | input | 1 | Asynchronous schedule enable from the controller |
| cfg_flag_i | input | 1 | Configure flag |
| hc_halted_i | input | 1 | Controller halted indication |
| hc_reset_i | input | 1 | Controller reset bit |
| pm_stat_i | input | 1 | Power-management status line |
| port_own_i | input | NUM_PORTS | Per-port ownership lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| smi_req_o | output | 1 | System-management interrupt request |

## Verification
On every cycle, the assertions check four things. An event always leaves its status bit set. A write of 1 with no event clears the bit. No status bit rises without an event. The rise-only sources fire only on a 0-to-1 step. They also check that a write lands in the enable field, that reset empties the word, and that the request implies a captured event. Other behaviours are shown only by the bench's scenarios, because they depend on which bit sits where: the field positions, the reserved zeros, the set-over-clear order on specific bits, the ignored falls of halted, reset and power-management, and the masking of the request by its enables.

// File: rtl/smi_evt_pkg.sv
package smi_evt_pkg;

    // Kind of transition that records an event
    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_RISE = 1'b1
    } edge_kind_e;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned NUM_FIXED = 6;
    localparam int unsigned STAT_LSB  = 16;

    // Event index order (shared by enable and status fields)
    localparam int unsigned EV_HCRST = 0;
    localparam int unsigned EV_HALT  = 1;
    localparam int unsigned EV_CFG   = 2;
    localparam int unsigned EV_PER   = 3;
    localparam int unsigned EV_ASYNC = 4;
    localparam int unsigned EV_PM    = 5;

    function automatic edge_kind_e kind_of(input int unsigned idx);
        if (idx == EV_HCRST || idx == EV_HALT || idx == EV_PM)
            return EDGE_RISE;
        return EDGE_ANY;
    endfunction

    function automatic logic edge_hit(input edge_kind_e k, input logic prev, input logic cur);
        return (k == EDGE_RISE) ? (cur & ~prev) : (cur ^ prev);
    endfunction

endpackage

// File: rtl/smi_evt_edge.sv
module smi_evt_edge
    import smi_evt_pkg::*;
#(
    parameter edge_kind_e KIND = EDGE_ANY
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic evt_o
);

    logic prev_q;

    // Tracks the input during reset too, so a level held across reset is no event
    always_ff @(posedge clk) begin
        prev_q <= sig_i;
    end

    assign evt_o = ~rst & edge_hit(KIND, prev_q, sig_i);

    generate
        if (KIND == EDGE_RISE) begin : g_rise
            // R5
            rise_only_chk: assert property (@(posedge clk) disable iff (rst)
                evt_o |-> (sig_i && !$past(sig_i)));
        end else begin : g_any
            // R4
            any_change_chk: assert property (@(posedge clk) disable iff (rst)
                evt_o |-> (sig_i != $past(sig_i)));
        end
    endgenerate

endmodule

// File: rtl/smi_evt_stat.sv
module smi_evt_stat #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);

    logic [N-1:0] stat_q;

    // Set has priority over a write-1 clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= evt_i | (stat_q & ~clr_i);
    end

    assign stat_o = stat_q;

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~evt_i)) |=> ((stat_q & $past(clr_i & ~evt_i)) == '0));

    // R9
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i == '0) |=> ((stat_q & ~$past(stat_q)) == '0));

endmodule

// File: rtl/smi_evt_reg.sv
module smi_evt_reg
    import smi_evt_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sched_per_en_i,
    input  logic                 sched_async_en_i,
    input  logic                 cfg_flag_i,
    input  logic                 hc_halted_i,
    input  logic                 hc_reset_i,
    input  logic                 pm_stat_i,
    input  logic [NUM_PORTS-1:0] port_own_i,
    input  logic                 reg_wr_i,
    input  logic [REG_W-1:0]     reg_wdata_i,
    output logic [REG_W-1:0]     reg_rdata_o,
    output logic                 smi_req_o
);

    localparam int unsigned NUM_EVT     = NUM_FIXED + NUM_PORTS;
    localparam int unsigned EN_PORT_LSB = STAT_LSB - NUM_PORTS;
    localparam int unsigned STAT_MSB    = STAT_LSB + NUM_EVT - 1;

    logic [NUM_EVT-1:0] mon;
    logic [NUM_EVT-1:0] evt;
    logic [NUM_EVT-1:0] clr;
    logic [NUM_EVT-1:0] stat;
    logic [NUM_EVT-1:0] en_q;
    logic [NUM_EVT-1:0] en_wr;

    assign mon = {port_own_i, pm_stat_i, sched_async_en_i, sched_per_en_i,
                  cfg_flag_i, hc_halted_i, hc_reset_i};

    generate
        for (genvar i = 0; i < NUM_EVT; i++) begin : g_edge
            smi_evt_edge #(.KIND(kind_of(i))) u_edge (
                .clk   (clk),
                .rst   (rst),
                .sig_i (mon[i]),
                .evt_o (evt[i])
            );
        end
    endgenerate

    assign en_wr = {reg_wdata_i[STAT_LSB-1:EN_PORT_LSB], reg_wdata_i[NUM_FIXED-1:0]};
    assign clr   = reg_wr_i ? reg_wdata_i[STAT_MSB:STAT_LSB] : '0;

    always_ff @(posedge clk) begin
        if (rst)           en_q <= '0;
        else if (reg_wr_i) en_q <= en_wr;
    end

    smi_evt_stat #(.N(NUM_EVT)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .clr_i  (clr),
        .stat_o (stat)
    );

    always_comb begin
        reg_rdata_o = '0;
        reg_rdata_o[NUM_FIXED-1:0]          = en_q[NUM_FIXED-1:0];
        reg_rdata_o[STAT_LSB-1:EN_PORT_LSB] = en_q[NUM_EVT-1:NUM_FIXED];
        reg_rdata_o[STAT_MSB:STAT_LSB]      = stat;
    end

    assign smi_req_o = |(stat & en_q);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reg_rdata_o == '0 && !smi_req_o));

    // R2
    enable_write_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_i |=> ({reg_rdata_o[STAT_LSB-1:EN_PORT_LSB], reg_rdata_o[NUM_FIXED-1:0]}
                      == $past(en_wr)));

    // R8
    req_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
        smi_req_o |-> (reg_rdata_o[STAT_MSB:STAT_LSB] != '0));

endmodule

// File: tb/test_smi_evt_reg.sv
module test_smi_evt_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mon = 8'h00;   // {port1, port0, pm, async, per, cfg, halted, reset}
    logic        wr = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        smi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    smi_evt_reg i_smi_evt_reg (
        .clk              (clk),
        .rst              (rst),
        .sched_per_en_i   (mon[3]),
        .sched_async_en_i (mon[4]),
        .cfg_flag_i       (mon[2]),
        .hc_halted_i      (mon[1]),
        .hc_reset_i       (mon[0]),
        .pm_stat_i        (mon[5]),
        .port_own_i       (mon[7:6]),
        .reg_wr_i         (wr),
        .reg_wdata_i      (wdata),
        .reg_rdata_o      (rdata),
        .smi_req_o        (smi)
    );

    typedef struct packed {
        logic [7:0]  mon;
        logic        wr;
        logic [31:0] wdata;
        logic [31:0] rd;
        logic        smi;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'd9}, // R9 quiet start
        '{8'h08, 1'b0, 32'h0000_0000, 32'h0008_0000, 1'b0, 4'd8}, // R8 periodic rise, masked
        '{8'h00, 1'b1, 32'h0008_0000, 32'h0008_0000, 1'b0, 4'd7}, // R7 fall + clear
        '{8'h00, 1'b1, 32'h0008_0000, 32'h0000_0000, 1'b0, 4'd6}, // R6 clear
        '{8'h02, 1'b0, 32'h0000_0000, 32'h0002_0000, 1'b0, 4'd5}, // R5 halted rise
        '{8'h00, 1'b1, 32'h0000_0002, 32'h0002_0002, 1'b1, 4'd8}, // R8 enable halted
        '{8'h00, 1'b1, 32'h0002_0002, 32'h0000_0002, 1'b0, 4'd6}, // R6 clear, keep enable
        '{8'h01, 1'b0, 32'h0000_0000, 32'h0001_0002, 1'b0, 4'd5}, // R5 reset-bit rise
        '{8'h00, 1'b0, 32'h0000_0000, 32'h0001_0002, 1'b0, 4'd5}, // R5 reset-bit fall ignored
        '{8'hC0, 1'b1, 32'hFFFF_FFFF, 32'h00C0_C03F, 1'b1, 4'd3}, // R3 all ones, R2 fields
        '{8'h40, 1'b1, 32'h00C1_C03F, 32'h0080_C03F, 1'b1, 4'd4}, // R4 port1 fall
        '{8'h50, 1'b1, 32'h0080_0010, 32'h0010_0010, 1'b1, 4'd4}, // R4 async rise
        '{8'h70, 1'b1, 32'h0010_0000, 32'h0020_0000, 1'b0, 4'd5}, // R5 pm rise
        '{8'h50, 1'b0, 32'h0000_0000, 32'h0020_0000, 1'b0, 4'd5}, // R5 pm fall ignored
        '{8'h54, 1'b0, 32'h0000_0000, 32'h0024_0000, 1'b0, 4'd4}, // R4 cfg rise
        '{8'h50, 1'b1, 32'h0004_0004, 32'h0024_0004, 1'b1, 4'd7}, // R7 cfg fall + clear
        '{8'h40, 1'b1, 32'h0024_0000, 32'h0010_0000, 1'b0, 4'd4}  // R4 async fall
    };

    task automatic check(input string tag, input logic [31:0] got_rd, input logic got_smi,
                         input logic [31:0] exp_rd, input logic exp_smi);
        checks++;
        if (got_rd !== exp_rd) begin
            fails++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, got_rd, exp_rd);
        end
        checks++;
        if (got_smi !== exp_smi) begin
            fails++;
            $display("FAIL %s smi actual=%b expected=%b", tag, got_smi, exp_smi);
        end
    endtask

    task automatic step(input logic [7:0] m, input logic w, input logic [31:0] d);
        @(negedge clk);
        mon   = m;
        wr    = w;
        wdata = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", rdata, smi, 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].mon, VECS[i].wr, VECS[i].wdata);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), rdata, smi,
                  VECS[i].rd, VECS[i].smi);
        end

        // R1: reset in the middle of activity empties everything
        step(8'h48, 1'b1, 32'h0000_C03F);
        @(negedge clk);
        rst = 1'b1;
        wr  = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", rdata, smi, 32'h0, 1'b0);

        // R9: inputs high across reset release record nothing
        @(negedge clk);
        mon = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R9 level across reset", rdata, smi, 32'h0, 1'b0);
        step(8'hFF, 1'b0, 32'h0);
        check("R9 held level", rdata, smi, 32'h0, 1'b0);

        // R4/R8: periodic fall with its enable written the same cycle
        step(8'hF7, 1'b1, 32'h0000_0008);
        check("R4 periodic fall", rdata, smi, 32'h0008_0008, 1'b1);

        // R5: halted and reset-bit falls record nothing
        step(8'hF4, 1'b0, 32'h0);
        check("R5 falls ignored", rdata, smi, 32'h0008_0008, 1'b1);

        // R6: writing zeros to status keeps it; R2 clears enables
        step(8'hF4, 1'b1, 32'h0000_0000);
        check("R6 write zero keeps", rdata, smi, 32'h0008_0000, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule